// File: doc/BRIEF.md
# Single-Step Angle Counter with Busy Pulse

This block holds the digital angle word of a tracking converter. A tracking loop outside the block asks for one step at a time, up or down. Each accepted request opens a converter-busy pulse of fixed length. The angle word moves by exactly one least significant step of the active resolution a fixed number of cycles after the pulse rises. A downstream transparent latch therefore has time to lock on the rising edge of busy before any bit changes. Later in the same pulse, a one-cycle data-valid strobe marks the point where the new word can be read.

The angle word is always 16 bits wide. Bit 15 weighs 180 degrees and each lower bit weighs half the bit above it. A single mode input selects the resolution. In fine (16-bit) mode the step is bit 0, worth 360/2^16 degrees. In coarse (14-bit) mode the step is bit 2, worth 360/2^14 degrees, and the two bits below it read zero. The count wraps in both directions.

A request that arrives while a pulse is running is held in a one-entry queue and starts its own pulse after the current one has ended. A request that arrives while that queue entry is already taken is discarded.

Top module: `angle_step_counter`

## Requirements
- R1: While rst_n is low, angle_o is 0, busy_o is 0 and valid_o is 0.
- R2: A request (step_req high at a clock edge) while busy_o is low and the queue is empty raises busy_o in the next cycle. busy_o then stays high for exactly BUSY_LEN cycles and falls for at least one cycle.
- R3: angle_o changes only in the cycle that is UPD_DLY cycles after the first busy cycle (the first busy cycle counts as 0), apart from the coarse-mode clearing of R9.
- R4: valid_o is high for exactly one cycle per pulse, in the cycle VALID_DLY cycles after the first busy cycle, which is after the angle change of that pulse.
- R5: With res16 = 1 (fine mode), a step with step_dir = 1 adds 1 to angle_o and a step with step_dir = 0 subtracts 1.
- R6: With res16 = 0 (coarse mode), a step adds or subtracts 4 (bit 2 is the LSB), and angle_o[1:0] read 0 from the cycle after the mode is sampled.
- R7: The count wraps modulo 2^16 in fine mode and modulo 2^14 on bits 15:2 in coarse mode, in both directions. For example, 0x0000 stepped down gives 0xFFFF in fine mode and 0xFFFC in coarse mode.
- R8: A request while busy_o is high is queued one deep with its direction. Its pulse starts after exactly one idle cycle following the current pulse. A further request while the queue is full is dropped.
- R9: When res16 goes from 1 to 0, angle_o[1:0] are cleared at the next clock edge and bits 15:2 are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | One-cycle step request from the tracking loop |
| step_dir | input | 1 | Direction of the request: 1 = up, 0 = down |
| res16 | input | 1 | Resolution select: 1 = 16-bit, 0 = 14-bit |
| angle_o | output | 16 | Angle word; bit 15 weighs 180 degrees |
| busy_o | output | 1 | Converter-busy pulse, one per step |
| valid_o | output | 1 | One-cycle data-valid strobe inside each pulse |

## Verification
The assertions assume that step_req, step_dir and res16 are synchronous to clk and settle well before each edge. They also assume that the delay parameters keep the order 1 <= UPD_DLY < VALID_DLY < BUSY_LEN, so the update and the strobe always fall inside the pulse. The step-size assertion also assumes that res16 was steady over the two edges before an update. The stimulus drives every input on the falling edge. The delay parameters stay at that order. Directed phases use a steady mode around each step. The pseudo-random phase toggles res16 only on a slow, fixed schedule, so that most steps see a stable mode, and also lets some mode changes land inside a pulse.

// File: rtl/angle_step_pkg.sv
package angle_step_pkg;
  parameter int ANGLE_W    = 16;
  parameter int FINE_EXTRA = 2;

  typedef logic [ANGLE_W-1:0] angle_t;

  // Weight of one step in units of the finest bit.
  function automatic angle_t lsb_weight(input logic fine);
    return fine ? angle_t'(1) : angle_t'(1) << FINE_EXTRA;
  endfunction

  // Clear the bits below the coarse LSB when coarse mode is active.
  function automatic angle_t coarse_mask(input angle_t a, input logic fine);
    angle_t m;
    m = a;
    if (!fine) m[FINE_EXTRA-1:0] = '0;
    return m;
  endfunction

  // One step in the given direction, wrapping on the word width.
  function automatic angle_t step_angle(input angle_t a, input logic up, input logic fine);
    angle_t s;
    s = up ? a + lsb_weight(fine) : a - lsb_weight(fine);
    return coarse_mask(s, fine);
  endfunction
endpackage

// File: rtl/step_queue.sv
module step_queue (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic dir,
  input  logic busy,
  output logic take,
  output logic take_dir,
  output logic q_full
);
  logic q_v, q_d;

  assign take     = !busy && (q_v || req);
  assign take_dir = q_v ? q_d : dir;
  assign q_full   = q_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v <= 1'b0;
      q_d <= 1'b0;
    end else if (take) begin
      q_v <= q_v && req;
      if (q_v && req) q_d <= dir;
    end else if (busy && req && !q_v) begin
      q_v <= 1'b1;
      q_d <= dir;
    end
  end

  // R8: a full slot keeps its direction until it is taken
  assert_queue_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(q_v) && $past(busy)) |-> (q_v && q_d == $past(q_d)));
endmodule

// File: rtl/busy_sequencer.sv
module busy_sequencer #(
  parameter int UPD_DLY   = 2,
  parameter int VALID_DLY = 8,
  parameter int BUSY_LEN  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_dir,
  output logic busy,
  output logic cur_dir,
  output logic upd_evt,
  output logic valid
);
  localparam int PH_W = (BUSY_LEN > 1) ? $clog2(BUSY_LEN) : 1;
  localparam logic [PH_W-1:0] PH_UPD  = PH_W'(UPD_DLY - 1);
  localparam logic [PH_W-1:0] PH_VAL  = PH_W'(VALID_DLY);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BUSY_LEN - 1);

  logic [PH_W-1:0] ph;

  assign upd_evt = busy && (ph == PH_UPD);
  assign valid   = busy && (ph == PH_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= '0;
      cur_dir <= 1'b0;
    end else if (take) begin
      busy    <= 1'b1;
      ph      <= '0;
      cur_dir <= take_dir;
    end else if (busy) begin
      if (ph == PH_LAST) begin
        busy <= 1'b0;
        ph   <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R2: a pulse only ends after its full length
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(ph) == PH_LAST));
  // R2: each pulse starts with phase zero
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ph == '0));
endmodule

// File: rtl/angle_register.sv
module angle_register
  import angle_step_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  logic   up,
  input  logic   res16,
  output angle_t angle
);
  always_ff @(posedge clk) begin
    if (!rst_n)   angle <= '0;
    else if (upd) angle <= step_angle(angle, up, res16);
    else          angle <= coarse_mask(angle, res16);
  end

  // R3: outside an update, the word holds while the mode is fine
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd) && $past(res16)) |-> $stable(angle));
  // R5: a fine step is plus or minus one
  assert_fine_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(res16)) |->
      (angle == ($past(up) ? $past(angle) + 16'd1 : $past(angle) - 16'd1)));
  // R6: coarse mode leaves the extra bits at zero
  assert_coarse_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(res16) |-> (angle[FINE_EXTRA-1:0] == '0));
endmodule

// File: rtl/angle_step_counter.sv
module angle_step_counter
  import angle_step_pkg::*;
#(
  parameter int UPD_DLY   = 2,
  parameter int VALID_DLY = 8,
  parameter int BUSY_LEN  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_req,
  input  logic               step_dir,
  input  logic               res16,
  output logic [ANGLE_W-1:0] angle_o,
  output logic               busy_o,
  output logic               valid_o
);
  logic take, take_dir, q_full, cur_dir, upd_evt;
  logic upd_seen;

  step_queue u_queue (
    .clk(clk), .rst_n(rst_n), .req(step_req), .dir(step_dir), .busy(busy_o),
    .take(take), .take_dir(take_dir), .q_full(q_full)
  );

  busy_sequencer #(.UPD_DLY(UPD_DLY), .VALID_DLY(VALID_DLY), .BUSY_LEN(BUSY_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .take_dir(take_dir),
    .busy(busy_o), .cur_dir(cur_dir), .upd_evt(upd_evt), .valid(valid_o)
  );

  angle_register u_angle (
    .clk(clk), .rst_n(rst_n), .upd(upd_evt), .up(cur_dir), .res16(res16), .angle(angle_o)
  );

  // Tracks whether this pulse's update has happened, for the strobe check.
  always_ff @(posedge clk) begin
    if (!rst_n || take) upd_seen <= 1'b0;
    else if (upd_evt)   upd_seen <= 1'b1;
  end

  // R4: the strobe comes after the angle update of its pulse
  assert_valid_after_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> upd_seen);
  // R4: the strobe lasts one cycle
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R8: a queued request starts after one idle cycle
  assert_queue_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && q_full) |=> busy_o);
  // R2: a pulse only starts on a request or a queued one
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(step_req || q_full));
endmodule

// File: tb/sim_angle_step_counter.sv
module sim_angle_step_counter;
  localparam int CLK_PERIOD = 10;
  localparam int UPD_DLY    = 2;
  localparam int VALID_DLY  = 8;
  localparam int BUSY_LEN   = 12;

  logic clk = 1'b0, rst_n = 1'b0, step_req = 1'b0, step_dir = 1'b0, res16 = 1'b1;
  logic [15:0] angle_o;
  logic busy_o, valid_o;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  angle_step_counter #(.UPD_DLY(UPD_DLY), .VALID_DLY(VALID_DLY), .BUSY_LEN(BUSY_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_dir(step_dir), .res16(res16),
    .angle_o(angle_o), .busy_o(busy_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit q[$];
  bit m_busy = 0, m_dir = 0, was_busy;
  int m_ph = 0, ph_old, m_angle = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ph = 0; m_angle = 0; q.delete();
    end else begin
      was_busy = m_busy;
      ph_old   = m_ph;
      if (was_busy) begin
        if (ph_old == UPD_DLY - 1)
          m_angle = m_angle + (m_dir ? 1 : -1) * (res16 ? 1 : 4);
        if (ph_old == BUSY_LEN - 1) begin m_busy = 0; m_ph = 0; end
        else m_ph = ph_old + 1;
        if (step_req && q.size() == 0) q.push_back(step_dir);
      end else if (q.size() > 0 || step_req) begin
        if (q.size() > 0) begin
          m_dir = q.pop_front();
          if (step_req) q.push_back(step_dir);
        end else m_dir = step_dir;
        m_busy = 1; m_ph = 0;
      end
      m_angle = ((m_angle % 65536) + 65536) % 65536;
      if (!res16) m_angle = (m_angle / 4) * 4;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(angle_o == 16'(m_angle), "R3 R5 R6 R7 R9 angle", angle_o, m_angle);
      check(busy_o == m_busy, "R2 R8 busy", busy_o, m_busy);
      check(valid_o == (m_busy && m_ph == VALID_DLY), "R4 valid", valid_o,
            int'(m_busy && m_ph == VALID_DLY));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic step(input bit up);
    @(negedge clk); step_req = 1; step_dir = up;
    @(negedge clk); step_req = 0;
  endtask

  task automatic wait_idle();
    repeat (BUSY_LEN * 3 + 4) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    check(angle_o == 0 && busy_o == 0 && valid_o == 0, "R1 reset", {angle_o, busy_o, valid_o}, 0);
    rst_n = 1;
    step(1); wait_idle();
    check(angle_o == 16'h0001, "R5 fine up", angle_o, 16'h0001);
    step(0); wait_idle(); step(0); wait_idle();
    check(angle_o == 16'hFFFF, "R7 fine wrap down", angle_o, 16'hFFFF);
    @(negedge clk); res16 = 0;
    @(negedge clk);
    check(angle_o == 16'hFFFC, "R9 clear extra bits", angle_o, 16'hFFFC);
    step(1); wait_idle();
    check(angle_o == 16'h0000, "R7 R6 coarse wrap up", angle_o, 16'h0000);
    step(0); wait_idle();
    check(angle_o == 16'hFFFC, "R6 coarse down", angle_o, 16'hFFFC);
    // three back-to-back requests: one runs, one queued, one dropped
    @(negedge clk); step_req = 1; step_dir = 1;
    repeat (3) @(negedge clk);
    step_req = 0;
    wait_idle();
    check(angle_o == 16'h0004, "R8 queue one deep", angle_o, 16'h0004);
    // pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step_req = (lfsr[1:0] == 2'b00);
      step_dir = lfsr[5];
      if (i % 331 == 330) res16 = ~res16;
    end
    step_req = 0;
    wait_idle();
    finish_run();
  end
endmodule